// File: doc/BRIEF.md
# Interrupt Destination Set Decoder

This block turns one interrupt routing request into the set of processor slots that receive it. A request carries an 8-bit destination, a bit that picks physical or logical addressing, a 2-bit shorthand, the slot index of the sender, a 3-bit delivery mode and two INIT qualifier bits. Each slot has a configuration entry that holds an 8-bit identifier, an 8-bit logical destination, a 4-bit addressing model and a present flag. The block returns a per-slot recipient mask and a few flags that tell the delivery logic what to do with that mask.

The request is sampled on the clock edge where `req_valid` is high. The result appears two edges later, with a one-cycle `out_valid` strobe. In lowest-priority mode the mask is cut down to a single winner, and that winner's index is also reported. A level-deassert INIT does not signal the targets. Instead it marks the mask for the identifier-to-arbitration copy. The interrupt state inside each target and the signalling wires themselves belong to other blocks.

Top module: `irq_dest_decoder`

## Requirements
- R1: While reset is low, and after it until the first result, `out_valid`, `out_mask`, `out_chosen`, `out_chosen_ok`, `out_vector`, `out_signal` and `out_arb_copy` are all zero.
- R2: A request sampled on a rising edge raises `out_valid` for exactly one cycle, right after the second following rising edge. No result appears without a request.
- R3: Shorthand 1 targets only the sender slot. Shorthand 2 targets all slots. Shorthand 3 targets all slots except the sender. For these three values the destination and the addressing bit have no effect.
- R4: With shorthand 0 and physical addressing (`req_logical`=0), destination 0xFF targets every present slot. Any other value targets the lowest-indexed slot whose identifier equals it, searching only the run of present slots that starts at slot 0. If no slot matches, the mask is empty.
- R5: With shorthand 0 and logical addressing, a slot with model 4'hF matches when destination AND its logical destination is non-zero.
- R6: With shorthand 0 and logical addressing, a slot with model 4'h0 matches when the upper nibbles of the destination and its logical destination are equal and the AND of their lower nibbles is non-zero. Any other model value never matches.
- R7: The logical match and the physical identifier search stop at the first absent slot. Slots above it never match, even when they are present.
- R8: A slot whose present flag is 0 is never set in `out_mask`.
- R9: Mode 1 (lowest priority) keeps only the lowest-indexed target. `out_chosen` gives that index and `out_chosen_ok` is 1 when a target exists. In every other mode both are 0.
- R10: Modes 0 (fixed), 2 (SMI), 4 (NMI) and 5 (INIT) pass the full target mask with `out_signal`=1. `out_vector` is 1 only in modes 0 and 1. Modes 3, 6 and 7 give an empty mask and all flags 0. `out_signal` is 1 in mode 1.
- R11: Mode 5 with `req_trig`=1 and `req_level`=0 passes the target mask with `out_arb_copy`=1 and `out_signal`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_dest | input | 8 | Destination field |
| req_logical | input | 1 | 0 physical, 1 logical addressing |
| req_shorthand | input | 2 | 0 field, 1 self, 2 all, 3 all but self |
| req_sender | input | SLOT_W | Slot index of the sender |
| req_mode | input | 3 | Delivery mode |
| req_trig | input | 1 | Trigger bit (INIT qualifier) |
| req_level | input | 1 | Level bit (INIT qualifier) |
| cfg_id | input | NUM_SLOTS*8 | Slot identifiers, slot i at bits [8i+7:8i] |
| cfg_ldest | input | NUM_SLOTS*8 | Logical destinations, slot i at bits [8i+7:8i] |
| cfg_model | input | NUM_SLOTS*4 | Addressing models, slot i at bits [4i+3:4i] |
| cfg_present | input | NUM_SLOTS | Present flag per slot |
| out_valid | output | 1 | One-cycle result strobe |
| out_mask | output | NUM_SLOTS | Recipient mask |
| out_chosen | output | SLOT_W | Lowest-priority winner index |
| out_chosen_ok | output | 1 | Winner index is meaningful |
| out_vector | output | 1 | Recipients take the vector |
| out_signal | output | 1 | Recipients are signalled |
| out_arb_copy | output | 1 | Recipients copy identifier into arbitration identifier |

## Verification
Internal state reaches the ports quickly. A wrong entry in the registered target mask shows up as a wrong `out_mask` bit on the very strobe of that request. A broken present-run chain first shows as extra matches above a hole, and only in configurations that contain a hole. A mode register that is wrong shows up on the same strobe as wrong flags or a mask that is not one-hot. Because every request is decoded on its own, a fault cannot hide for more than one result. The sweep covers every destination value with both addressing kinds and all shorthands over configurations that are full, holed, duplicated and empty.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;

    localparam int DEST_W  = 8;
    localparam int MODEL_W = 4;
    localparam int MODE_W  = 3;

    localparam logic [DEST_W-1:0]  DEST_BCAST    = 8'hFF;
    localparam logic [MODEL_W-1:0] MODEL_FLAT    = 4'hF;
    localparam logic [MODEL_W-1:0] MODEL_CLUSTER = 4'h0;

    localparam logic [MODE_W-1:0] DM_FIXED  = 3'd0;
    localparam logic [MODE_W-1:0] DM_LOWEST = 3'd1;
    localparam logic [MODE_W-1:0] DM_SMI    = 3'd2;
    localparam logic [MODE_W-1:0] DM_NMI    = 3'd4;
    localparam logic [MODE_W-1:0] DM_INIT   = 3'd5;

    typedef enum logic [1:0] {
        SH_FIELD  = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

endpackage

// File: rtl/irq_slot_match.sv
module irq_slot_match
    import irq_dest_pkg::*;
(
    input  logic [DEST_W-1:0]  dest,
    input  logic               in_run,
    input  logic [DEST_W-1:0]  slot_id,
    input  logic [DEST_W-1:0]  slot_ldest,
    input  logic [MODEL_W-1:0] slot_model,
    output logic               phys_hit,
    output logic               log_hit
);

    localparam int HALF = DEST_W / 2;

    logic flat_ok;
    logic clus_ok;

    always_comb begin
        flat_ok  = (slot_model == MODEL_FLAT) && ((dest & slot_ldest) != '0);
        clus_ok  = (slot_model == MODEL_CLUSTER)
                && (dest[DEST_W-1:HALF] == slot_ldest[DEST_W-1:HALF])
                && ((dest[HALF-1:0] & slot_ldest[HALF-1:0]) != '0);
        phys_hit = in_run && (slot_id == dest);
        log_hit  = in_run && (flat_ok || clus_ok);
    end

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] vec,
    output logic [N-1:0] onehot,
    output logic [W-1:0] idx,
    output logic         any
);

    always_comb begin
        onehot = '0;
        idx    = '0;
        any    = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                onehot    = '0;
                onehot[i] = 1'b1;
                idx       = W'(i);
                any       = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_dest_decoder.sv
module irq_dest_decoder
    import irq_dest_pkg::*;
#(
    parameter  int NUM_SLOTS = 8,
    localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [DEST_W-1:0]             req_dest,
    input  logic                          req_logical,
    input  logic [1:0]                    req_shorthand,
    input  logic [SLOT_W-1:0]             req_sender,
    input  logic [MODE_W-1:0]             req_mode,
    input  logic                          req_trig,
    input  logic                          req_level,
    input  logic [NUM_SLOTS*DEST_W-1:0]   cfg_id,
    input  logic [NUM_SLOTS*DEST_W-1:0]   cfg_ldest,
    input  logic [NUM_SLOTS*MODEL_W-1:0]  cfg_model,
    input  logic [NUM_SLOTS-1:0]          cfg_present,
    output logic                          out_valid,
    output logic [NUM_SLOTS-1:0]          out_mask,
    output logic [SLOT_W-1:0]             out_chosen,
    output logic                          out_chosen_ok,
    output logic                          out_vector,
    output logic                          out_signal,
    output logic                          out_arb_copy
);

    typedef struct packed {
        logic                 v;
        logic [NUM_SLOTS-1:0] tgt;
        logic [MODE_W-1:0]    mode;
        logic                 trig;
        logic                 level;
    } stage1_t;

    typedef struct packed {
        logic                 v;
        logic [NUM_SLOTS-1:0] mask;
        logic [SLOT_W-1:0]    chosen;
        logic                 chosen_ok;
        logic                 vec;
        logic                 sig;
        logic                 arb;
    } stage2_t;

    typedef struct packed {
        stage1_t s1;
        stage2_t s2;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SLOTS-1:0] run_ok;
    logic [NUM_SLOTS-1:0] phys_hit;
    logic [NUM_SLOTS-1:0] log_hit;
    logic [NUM_SLOTS-1:0] phys_first;
    logic [NUM_SLOTS-1:0] self_bit;
    logic [NUM_SLOTS-1:0] field_set;
    logic [NUM_SLOTS-1:0] tgt_set;
    logic [NUM_SLOTS-1:0] low_one;
    logic [SLOT_W-1:0]    low_idx;
    logic                 low_any;

    // Present run from slot 0 and the sender's one-hot bit
    always_comb begin
        logic run;
        run = 1'b1;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            run       = run & cfg_present[i];
            run_ok[i] = run;
            self_bit[i] = (req_sender == SLOT_W'(i));
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        irq_slot_match u_match (
            .dest       (req_dest),
            .in_run     (run_ok[g]),
            .slot_id    (cfg_id[g*DEST_W +: DEST_W]),
            .slot_ldest (cfg_ldest[g*DEST_W +: DEST_W]),
            .slot_model (cfg_model[g*MODEL_W +: MODEL_W]),
            .phys_hit   (phys_hit[g]),
            .log_hit    (log_hit[g])
        );
    end

    // First identifier match wins in physical addressing
    always_comb begin
        phys_first = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (phys_hit[i]) begin
                phys_first    = '0;
                phys_first[i] = 1'b1;
            end
        end
    end

    always_comb begin
        if (req_logical) begin
            field_set = log_hit;
        end else if (req_dest == DEST_BCAST) begin
            field_set = cfg_present;
        end else begin
            field_set = phys_first;
        end
        case (shorthand_e'(req_shorthand))
            SH_SELF:   tgt_set = self_bit & cfg_present;
            SH_ALL:    tgt_set = cfg_present;
            SH_OTHERS: tgt_set = cfg_present & ~self_bit;
            default:   tgt_set = field_set;
        endcase
    end

    irq_lowest_pick #(
        .N (NUM_SLOTS),
        .W (SLOT_W)
    ) u_pick (
        .vec    (st_q.s1.tgt),
        .onehot (low_one),
        .idx    (low_idx),
        .any    (low_any)
    );

    always_comb begin
        st_d = st_q;

        st_d.s1.v     = req_valid;
        st_d.s1.tgt   = tgt_set;
        st_d.s1.mode  = req_mode;
        st_d.s1.trig  = req_trig;
        st_d.s1.level = req_level;

        st_d.s2.v         = st_q.s1.v;
        st_d.s2.mask      = '0;
        st_d.s2.chosen    = '0;
        st_d.s2.chosen_ok = 1'b0;
        st_d.s2.vec       = 1'b0;
        st_d.s2.sig       = 1'b0;
        st_d.s2.arb       = 1'b0;
        if (st_q.s1.v) begin
            case (st_q.s1.mode)
                DM_FIXED: begin
                    st_d.s2.mask = st_q.s1.tgt;
                    st_d.s2.vec  = 1'b1;
                    st_d.s2.sig  = 1'b1;
                end
                DM_LOWEST: begin
                    st_d.s2.mask      = low_one;
                    st_d.s2.chosen    = low_idx;
                    st_d.s2.chosen_ok = low_any;
                    st_d.s2.vec       = 1'b1;
                    st_d.s2.sig       = 1'b1;
                end
                DM_SMI, DM_NMI: begin
                    st_d.s2.mask = st_q.s1.tgt;
                    st_d.s2.sig  = 1'b1;
                end
                DM_INIT: begin
                    st_d.s2.mask = st_q.s1.tgt;
                    if (st_q.s1.trig && !st_q.s1.level) begin
                        st_d.s2.arb = 1'b1;
                    end else begin
                        st_d.s2.sig = 1'b1;
                    end
                end
                default: begin
                    st_d.s2.mask = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid     = st_q.s2.v;
    assign out_mask      = st_q.s2.mask;
    assign out_chosen    = st_q.s2.chosen;
    assign out_chosen_ok = st_q.s2.chosen_ok;
    assign out_vector    = st_q.s2.vec;
    assign out_signal    = st_q.s2.sig;
    assign out_arb_copy  = st_q.s2.arb;

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ##1 out_valid);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(req_valid, 2));

    assert_absent_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_mask & ~$past(cfg_present, 2)) == '0));

    assert_lowest_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_chosen_ok) |-> ($countones(out_mask) == 1));

    assert_arb_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_arb_copy |-> !out_signal);

    assert_idle_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_signal && !out_arb_copy) |-> (out_mask == '0));

endmodule

// File: tb/irq_dest_decoder_tb_top.sv
module irq_dest_decoder_tb_top;

    localparam int NS = 8;
    localparam int SW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [7:0]      req_dest = '0;
    logic            req_logical = 1'b0;
    logic [1:0]      req_shorthand = '0;
    logic [SW-1:0]   req_sender = '0;
    logic [2:0]      req_mode = '0;
    logic            req_trig = 1'b0;
    logic            req_level = 1'b0;
    logic [NS*8-1:0] cfg_id = '0;
    logic [NS*8-1:0] cfg_ldest = '0;
    logic [NS*4-1:0] cfg_model = '0;
    logic [NS-1:0]   cfg_present = '0;
    logic            out_valid;
    logic [NS-1:0]   out_mask;
    logic [SW-1:0]   out_chosen;
    logic            out_chosen_ok;
    logic            out_vector;
    logic            out_signal;
    logic            out_arb_copy;

    int n_checks = 0;
    int n_fails  = 0;

    logic [7:0] t_id    [NS];
    logic [7:0] t_ldest [NS];
    logic [3:0] t_model [NS];

    always #5 clk = ~clk;

    irq_dest_decoder #(.NUM_SLOTS(NS)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_dest      (req_dest),
        .req_logical   (req_logical),
        .req_shorthand (req_shorthand),
        .req_sender    (req_sender),
        .req_mode      (req_mode),
        .req_trig      (req_trig),
        .req_level     (req_level),
        .cfg_id        (cfg_id),
        .cfg_ldest     (cfg_ldest),
        .cfg_model     (cfg_model),
        .cfg_present   (cfg_present),
        .out_valid     (out_valid),
        .out_mask      (out_mask),
        .out_chosen    (out_chosen),
        .out_chosen_ok (out_chosen_ok),
        .out_vector    (out_vector),
        .out_signal    (out_signal),
        .out_arb_copy  (out_arb_copy)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic load_config(input int c);
        for (int i = 0; i < NS; i++) begin
            t_id[i]    = (c == 2) ? 8'((i / 2) * 5) : 8'((i * 37 + c * 11) % 256);
            t_ldest[i] = 8'(((i * 53 + c * 29) % 256) ^ ((i * 16) % 256));
            case ((i + c) % 3)
                0:       t_model[i] = 4'h0;
                1:       t_model[i] = 4'hF;
                default: t_model[i] = 4'h4;
            endcase
            cfg_id[i*8 +: 8]    = t_id[i];
            cfg_ldest[i*8 +: 8] = t_ldest[i];
            cfg_model[i*4 +: 4] = t_model[i];
        end
        case (c)
            0:       cfg_present = 8'hFF;
            1:       cfg_present = 8'hFB;
            2:       cfg_present = 8'h7F;
            default: cfg_present = 8'h00;
        endcase
    endtask

    // Target set from the requirements (R3..R8)
    function automatic logic [NS-1:0] want_targets(input logic [7:0] d, input logic lg,
                                                   input logic [1:0] sh, input int snd);
        logic [NS-1:0] r;
        logic          alive;
        logic          found;
        r = '0;
        alive = 1'b1;
        found = 1'b0;
        if (sh == 2'd1) begin
            r[snd] = cfg_present[snd];
        end else if (sh == 2'd2) begin
            r = cfg_present;
        end else if (sh == 2'd3) begin
            r = cfg_present;
            r[snd] = 1'b0;
        end else if (!lg && d == 8'hFF) begin
            r = cfg_present;
        end else begin
            for (int i = 0; i < NS; i++) begin
                alive = alive && cfg_present[i];
                if (alive) begin
                    if (!lg) begin
                        if (!found && t_id[i] == d) begin
                            r[i] = 1'b1;
                            found = 1'b1;
                        end
                    end else if (t_model[i] == 4'hF) begin
                        r[i] = (d & t_ldest[i]) != 8'h00;
                    end else if (t_model[i] == 4'h0) begin
                        r[i] = (d[7:4] == t_ldest[i][7:4]) && ((d[3:0] & t_ldest[i][3:0]) != 4'h0);
                    end
                end
            end
        end
        return r;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", 32'(out_valid), 32'd0);
        check("R1 reset mask", 32'({out_mask, out_chosen, out_chosen_ok, out_vector,
                                    out_signal, out_arb_copy}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 idle after reset", 32'({out_valid, out_mask, out_chosen, out_chosen_ok,
                                          out_vector, out_signal, out_arb_copy}), 32'd0);

        for (int c = 0; c < 4; c++) begin
            load_config(c);
            for (int d = 0; d < 256; d++) begin
                for (int lg = 0; lg < 2; lg++) begin
                    for (int sh = 0; sh < 4; sh++) begin
                        logic [NS-1:0] tgt;
                        logic [NS-1:0] e_mask;
                        logic [SW-1:0] e_ch;
                        logic          e_ok, e_vec, e_sig, e_arb;
                        logic [2:0]    md;
                        logic          tr, lv;
                        int            snd;
                        string         mtag, ftag;
                        md  = 3'((d + sh * 3 + lg) % 8);
                        snd = (d * 5 + sh) % NS;
                        tr  = 1'((d >> 6) & 1);
                        lv  = 1'(((d >> 7) & 1) ^ lg);
                        tgt = want_targets(8'(d), 1'(lg), 2'(sh), snd);
                        e_mask = '0; e_ch = '0; e_ok = 1'b0;
                        e_vec = 1'b0; e_sig = 1'b0; e_arb = 1'b0;
                        case (md)
                            3'd0: begin e_mask = tgt; e_vec = 1'b1; e_sig = 1'b1; end
                            3'd1: begin
                                e_vec = 1'b1; e_sig = 1'b1;
                                for (int i = NS - 1; i >= 0; i--) begin
                                    if (tgt[i]) begin
                                        e_mask = '0; e_mask[i] = 1'b1;
                                        e_ch = SW'(i); e_ok = 1'b1;
                                    end
                                end
                            end
                            3'd2, 3'd4: begin e_mask = tgt; e_sig = 1'b1; end
                            3'd5: begin
                                e_mask = tgt;
                                if (tr && !lv) e_arb = 1'b1;
                                else e_sig = 1'b1;
                            end
                            default: e_mask = '0;
                        endcase
                        if (md == 3'd1)       mtag = "R9 mask";
                        else if (c == 3)      mtag = "R8 mask";
                        else if (sh != 0)     mtag = "R3 mask";
                        else if (lg == 0)     mtag = "R4 mask";
                        else if (c == 1)      mtag = "R7 mask";
                        else                  mtag = "R5_R6 mask";
                        if (md == 3'd1)                   ftag = "R9 flags";
                        else if (md == 3'd5 && tr && !lv) ftag = "R11 flags";
                        else                              ftag = "R10 flags";

                        req_valid = 1'b1; req_dest = 8'(d); req_logical = 1'(lg);
                        req_shorthand = 2'(sh); req_sender = SW'(snd);
                        req_mode = md; req_trig = tr; req_level = lv;
                        @(negedge clk);
                        req_valid = 1'b0;
                        req_dest = ~req_dest;
                        req_shorthand = ~req_shorthand;
                        check("R2 not early", 32'(out_valid), 32'd0);
                        @(negedge clk);
                        check(mtag, 32'(out_mask), 32'(e_mask));
                        check(ftag, 32'({out_valid, out_chosen, out_chosen_ok, out_vector,
                                         out_signal, out_arb_copy}),
                              32'({1'b1, e_ch, e_ok, e_vec, e_sig, e_arb}));
                    end
                end
            end
        end
        @(negedge clk);
        check("R2 single pulse", 32'(out_valid), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule